// File: doc/BRIEF.md
# Static-Memory Bank Configuration and Access Gate

This block keeps one configuration word per chip-select bank of an external static-memory controller and screens every incoming bus request against the word of its target bank, before the request is passed on to the memory sequencer. Software programs the words through a small write port and reads them back through a combinational read path. The request side gives a bank index, a read/write flag and an address. One cycle later the block either forwards the request, or refuses it with an error flag and a done flag raised together for a single cycle, so the requester is never left waiting.

A forwarded request comes with attributes taken from the bank word. These are an access-mode code derived from the memory type and the extended-timing bit, an effective multiplexing flag, and the bus width. Bank 0 leaves reset already usable for a NOR device. The other banks leave reset disabled and set up for SRAM.

Configuration word layout (`CFG_W` = 7): bit 0 bank enable, bit 1 address/data multiplexing, bits 3:2 memory type (0 SRAM, 1 PSRAM, 2 NOR, 3 reserved), bit 4 width (0 = 8-bit, 1 = 16-bit), bit 5 write enable, bit 6 extended timing.

Top module: `bank_cfg_gate`

## Requirements
- R1: After reset, bank 0 reads back 7'h3B (enabled, multiplexed, NOR, 16-bit, writable) and every other bank reads back 7'h32 (disabled, multiplexed, SRAM, 16-bit, writable). The request outputs are all low.
- R2: A configuration write loads `cfg_wdata` into the bank given by `cfg_sel` at the clock edge. `cfg_rdata` then shows the new word, and no other bank changes.
- R3: A request to a bank whose enable bit (bit 0) is clear, or to a bank index of `NBANKS` or above, gives `rsp_err` and `rsp_done` on the cycle after it and no `fwd_valid`.
- R4: A write request to a bank whose write-enable bit (bit 5) is clear is refused as in R3. A read request to that same bank is forwarded.
- R5: A request to a bank whose memory type (bits 3:2) is 3 is refused as in R3.
- R6: A legal request raises `fwd_valid` for one cycle, on the cycle after it, with the request's bank, write flag and address. No error is raised.
- R7: `fwd_mode` is 3 when the extended-timing bit (bit 6) is set. Otherwise it is 2 for NOR type and 1 for SRAM or PSRAM type.
- R8: `fwd_mux` is the multiplexing bit (bit 1) when the type is PSRAM or NOR, and 0 for SRAM.
- R9: `fwd_wide` equals the width bit (bit 4) of the requested bank.
- R10: `rsp_err` and `rsp_done` each last one cycle, are always raised together, and never coincide with `fwd_valid`. Without a request, all three stay low.
- R11: A request is judged against the bank word held before a configuration write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | BANK_W | Bank addressed by write and read-back |
| cfg_wdata | input | CFG_W | Configuration word to write |
| cfg_rdata | output | CFG_W | Current word of bank `cfg_sel` |
| req_valid | input | 1 | Request strobe |
| req_bank | input | BANK_W | Target bank of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| fwd_valid | output | 1 | Request forwarded to the sequencer |
| fwd_bank | output | BANK_W | Forwarded bank |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_mode | output | 2 | Access mode: 1, 2 or 3 (extended) |
| fwd_mux | output | 1 | Effective address/data multiplexing |
| fwd_wide | output | 1 | 16-bit bus when 1 |
| rsp_err | output | 1 | Request refused |
| rsp_done | output | 1 | Refused request completed |

## Verification
On every cycle, the assertions check the shape of the response: error and done are raised together, neither ever meets a forward, any outcome follows a request on the cycle before, a refusal lasts a single cycle, and a forwarded mode code is never 0. Only the bench scenarios can show that the decisions are correct. These are the per-bank reset words, which condition (disabled bank, write protection, reserved type) refuses a request, the mode, multiplexing and width mapping for each memory type, and the ordering against a configuration write in the same cycle.

// File: rtl/bank_cfg_gate.sv
module bank_cfg_gate #(
  parameter int NBANKS = 4,
  parameter int ADDR_W = 24
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfg_wr,
  input  logic [((NBANKS > 1) ? $clog2(NBANKS) : 1)-1:0] cfg_sel,
  input  logic [6:0]                            cfg_wdata,
  output logic [6:0]                            cfg_rdata,
  input  logic                                  req_valid,
  input  logic [((NBANKS > 1) ? $clog2(NBANKS) : 1)-1:0] req_bank,
  input  logic                                  req_write,
  input  logic [ADDR_W-1:0]                     req_addr,
  output logic                                  fwd_valid,
  output logic [((NBANKS > 1) ? $clog2(NBANKS) : 1)-1:0] fwd_bank,
  output logic                                  fwd_write,
  output logic [ADDR_W-1:0]                     fwd_addr,
  output logic [1:0]                            fwd_mode,
  output logic                                  fwd_mux,
  output logic                                  fwd_wide,
  output logic                                  rsp_err,
  output logic                                  rsp_done
);
  localparam int BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1;
  localparam int CFG_W  = 7;
  localparam logic [CFG_W-1:0] RST_B0   = 7'h3B;
  localparam logic [CFG_W-1:0] RST_REST = 7'h32;

  logic [CFG_W-1:0] cfg_q [NBANKS];

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[g] <= (g == 0) ? RST_B0 : RST_REST;
      else if (cfg_wr && cfg_sel == BANK_W'(g))
        cfg_q[g] <= cfg_wdata;
    end
  end

  logic [CFG_W-1:0] rd_word, rq_word;
  logic             rq_hit;

  always_comb begin
    rd_word = '0;
    rq_word = '0;
    rq_hit  = 1'b0;
    for (int i = 0; i < NBANKS; i++) begin
      if (cfg_sel == BANK_W'(i)) rd_word = cfg_q[i];
      if (req_bank == BANK_W'(i)) begin
        rq_word = cfg_q[i];
        rq_hit  = 1'b1;
      end
    end
  end

  assign cfg_rdata = rd_word;

  wire [1:0] rq_type = rq_word[3:2];
  wire refuse = !rq_hit || !rq_word[0] || (rq_type == 2'd3) ||
                (req_write && !rq_word[5]);
  wire [1:0] mode_n = rq_word[6] ? 2'd3 : ((rq_type == 2'd2) ? 2'd2 : 2'd1);
  wire mux_n = rq_word[1] && (rq_type == 2'd1 || rq_type == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_done  <= 1'b0;
      fwd_bank  <= '0;
      fwd_write <= 1'b0;
      fwd_addr  <= '0;
      fwd_mode  <= 2'd0;
      fwd_mux   <= 1'b0;
      fwd_wide  <= 1'b0;
    end else begin
      fwd_valid <= req_valid && !refuse;
      rsp_err   <= req_valid && refuse;
      rsp_done  <= req_valid && refuse;
      if (req_valid && !refuse) begin
        fwd_bank  <= req_bank;
        fwd_write <= req_write;
        fwd_addr  <= req_addr;
        fwd_mode  <= mode_n;
        fwd_mux   <= mux_n;
        fwd_wide  <= rq_word[4];
      end
    end
  end

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err == rsp_done);
  // R10
  err_fwd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_err && fwd_valid));
  // R6
  outcome_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid || rsp_err) |-> $past(req_valid));
  // R10
  err_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_err && !$past(req_valid, 2)) |=> !rsp_err);
  // R7
  mode_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> fwd_mode != 2'd0);
endmodule

// File: tb/bank_cfg_gate_test.sv
module bank_cfg_gate_test;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0;
  logic [1:0] cfg_sel = 0;
  logic [6:0] cfg_wdata = 0, cfg_rdata;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_bank = 0;
  logic [23:0] req_addr = 0;
  logic fwd_valid, fwd_write, fwd_mux, fwd_wide, rsp_err, rsp_done;
  logic [1:0] fwd_bank, fwd_mode;
  logic [23:0] fwd_addr;
  int checks = 0, errors = 0;

  bank_cfg_gate uut (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [1:0] b, logic [6:0] w);
    @(negedge clk); cfg_wr = 1; cfg_sel = b; cfg_wdata = w;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic req(logic [1:0] b, logic wr, logic [23:0] a);
    @(negedge clk); req_valid = 1; req_bank = b; req_write = wr; req_addr = a;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic t_reset;
    for (int b = 0; b < 4; b++) begin
      cfg_sel = 2'(b); #1;
      chk("R1 reset word", cfg_rdata, b == 0 ? 7'h3B : 7'h32);
    end
    chk("R1 idle outputs", {fwd_valid, rsp_err, rsp_done}, 0);
  endtask

  task automatic t_cfg_write;
    cfg(2, 7'h55);
    cfg_sel = 2; #1; chk("R2 written bank", cfg_rdata, 7'h55);
    cfg_sel = 1; #1; chk("R2 other bank kept", cfg_rdata, 7'h32);
    cfg_sel = 3; #1; chk("R2 other bank kept", cfg_rdata, 7'h32);
  endtask

  task automatic t_disabled;
    req(1, 0, 24'h100);
    chk("R3 disabled err/done/fwd", {rsp_err, rsp_done, fwd_valid}, 3'b110);
    @(negedge clk);
    chk("R10 err one cycle", {rsp_err, rsp_done, fwd_valid}, 0);
  endtask

  task automatic t_write_protect;
    cfg(1, 7'h11);
    req(1, 1, 24'h200);
    chk("R4 write refused", {rsp_err, rsp_done, fwd_valid}, 3'b110);
    req(1, 0, 24'h204);
    chk("R4 read forwarded", {rsp_err, fwd_valid}, 2'b01);
    chk("R6 fwd fields", {fwd_bank, fwd_write, fwd_addr}, {2'd1, 1'b0, 24'h204});
  endtask

  task automatic t_reserved;
    cfg(1, 7'h2D);
    req(1, 0, 24'h300);
    chk("R5 reserved type refused", {rsp_err, rsp_done, fwd_valid}, 3'b110);
  endtask

  task automatic t_modes;
    req(0, 1, 24'hABCDE);
    chk("R6 bank0 forward", {fwd_valid, rsp_err, fwd_bank, fwd_write, fwd_addr},
        {1'b1, 1'b0, 2'd0, 1'b1, 24'hABCDE});
    chk("R7 R8 R9 NOR", {fwd_mode, fwd_mux, fwd_wide}, {2'd2, 1'b1, 1'b1});
    cfg(1, 7'h27);
    req(1, 0, 24'h10);
    chk("R7 R8 R9 PSRAM", {fwd_valid, fwd_mode, fwd_mux, fwd_wide}, {1'b1, 2'd1, 1'b1, 1'b0});
    cfg(2, 7'h33);
    req(2, 1, 24'h20);
    chk("R7 R8 R9 SRAM", {fwd_valid, fwd_mode, fwd_mux, fwd_wide}, {1'b1, 2'd1, 1'b0, 1'b1});
    cfg(3, 7'h69);
    req(3, 0, 24'h30);
    chk("R7 R8 extended", {fwd_valid, fwd_mode, fwd_mux, fwd_wide}, {1'b1, 2'd3, 1'b0, 1'b0});
    @(negedge clk);
    chk("R10 no request idle", {fwd_valid, rsp_err, rsp_done}, 0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfg_wr = 1; cfg_sel = 3; cfg_wdata = 7'h68;
    req_valid = 1; req_bank = 3; req_write = 0; req_addr = 24'h40;
    @(negedge clk); cfg_wr = 0; req_valid = 0;
    chk("R11 old word used", {fwd_valid, rsp_err}, 2'b10);
    req(3, 0, 24'h44);
    chk("R11 new word after", {fwd_valid, rsp_err}, 2'b01);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_cfg_write;
    t_disabled;
    t_write_protect;
    t_reserved;
    t_modes;
    t_same_cycle;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule